// File: doc/BRIEF.md
# Indexed Host Register Port with Strapped Base Address

This block gives a host on an 8-bit I/O bus access to a small register file through two neighbouring I/O locations. The even location holds a pointer that selects a register, and the odd location moves data to or from the register that the pointer selects. Every bus signal is sampled on the internal clock. A write takes effect only after its strobe has been released.

While reset is active, the chip-select level picks how the block finds its I/O base. If chip select is low, the base is fixed at D6h/D7h. If chip select is high, the base stays unknown until the first write with chip select low. That write supplies the base from its data byte, whatever address it carries. A control register at pointer value FFh accepts writes only. Bit 0 of that register opens or closes access to every other register. Bit 2 picks whether the write strobe passes through a two-clock delay before it is used. Reading FFh returns a fixed version code. The general registers are driven out of the block in parallel for the rest of the chip.

Top module: `idx_reg_port`

## Requirements
- R1: When `csN` is low in the last clock of reset, the block answers at base D6h. The pointer port is D6h and the data port is D7h, so `doe` rises on a data read at D7h straight after reset.
- R2: When `csN` is high in the last clock of reset, the first write with `csN` low loads the base from `din[7:1]`, whatever its address. From then on the block answers only at that base.
- R3: Until the base has been captured, `doe` stays low for every read.
- R4: An access whose `addr[7:1]` differs from the base has no effect. A write changes no register and a read leaves `doe` low.
- R5: The pointer port (`addr[0]`=0) accepts writes only. A read there leaves `doe` low.
- R6: While FFh bit 0 is 0, data reads of any pointer other than FFh return 00h, and data writes to the general registers are dropped. `regsOut` keeps its contents.
- R7: While FFh bit 0 is 1, pointer values 10h..13h reach general registers 0..3. These can be written and read back, and register k drives `regsOut[8k+7:8k]`. All of them clear to 00h at reset.
- R8: A data read with the pointer at FFh returns 30h: version code 3 in bits 7..4 and zeros in bits 3..0, whatever was written there.
- R9: A data read of an unimplemented pointer value returns 00h with `doe` high.
- R10: With FFh bit 2 = 1, a write becomes visible on `regsOut` after the 2nd rising edge, counted from the first edge that samples the released strobe. With bit 2 = 0 (the reset value), it becomes visible after the 4th such edge.
- R11: While enabled, a data read with the pointer at 00h returns the base as `{base[7:1],0}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high; `csN` is strapped during it |
| csN | input | 1 | Chip select, active low |
| iowrN | input | 1 | Write strobe, active low |
| iordN | input | 1 | Read strobe, active low |
| addr | input | 8 | I/O address; bits 7..1 decode, bit 0 selects pointer or data port |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host, 00h when not driven |
| doe | output | 1 | High while the block drives a data-port read |
| regsOut | output | 32 | General registers 0..3 packed, register k in bits 8k+7:8k |
| globalEn | output | 1 | Current value of FFh bit 0 |

## Verification
Write-strobe latency is the hardest behaviour to pin down from the ports. The commit time depends on FFh bit 2, and that bit is itself set by a write through the same path. The stimulus first runs a general-register write in the default delayed mode, then rewrites FFh to turn the delay off, then runs a second general-register write. In each case `regsOut` is sampled after every edge that follows the strobe release. Programmable-base mode needs a second reset with chip select held high, followed by reads that must be ignored before the capturing write is issued.

// File: rtl/idx_reg_port_pkg.sv
package idx_reg_port_pkg;
  // Commit strobes from the bus control to the register datapath.
  typedef struct packed {
    logic       capBase;  // capture of the decode base (programmable mode)
    logic       wrIndex;  // pointer port write
    logic       wrData;   // data port write
    logic [7:0] wdata;    // byte latched while the strobe was active
  } wr_cmd_t;
endpackage

// File: rtl/idx_reg_port_ctrl.sv
module idx_reg_port_ctrl
  import idx_reg_port_pkg::*;
#(
  parameter logic [7:0] FIXED_BASE = 8'hD6,
  parameter int         DLY_CYC    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       iowrN,
  input  logic       iordN,
  input  logic [7:0] addr,
  input  logic [7:0] din,
  input  logic       delayOff,
  output wr_cmd_t    cmd,
  output logic       rdData,
  output logic [6:0] baseAddr,
  output logic       addrValid,
  output logic       fixedMode
);
  localparam int STG = DLY_CYC + 1;

  logic           hit, rawWr, eff, effQ, commit;
  logic [STG-1:0] stg;
  logic           latA;
  logic [7:0]     latD;

  assign hit    = (addr[7:1] == baseAddr);
  assign rawWr  = ~csN & ~iowrN & (addrValid ? hit : 1'b1);
  assign eff    = delayOff ? stg[0] : stg[STG-1];
  assign commit = effQ & ~eff;
  assign rdData = ~csN & ~iordN & addrValid & hit & addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fixedMode <= ~csN;
      addrValid <= ~csN;
      baseAddr  <= ~csN ? FIXED_BASE[7:1] : 7'd0;
      stg       <= '0;
      effQ      <= 1'b0;
      latA      <= 1'b0;
      latD      <= '0;
    end else begin
      stg  <= {stg[STG-2:0], rawWr};
      effQ <= eff;
      if (rawWr) begin
        latA <= addr[0];
        latD <= din;
      end
      if (commit && !addrValid) begin
        baseAddr  <= latD[7:1];
        addrValid <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd.capBase = commit & ~addrValid;
    cmd.wrIndex = commit & addrValid & ~latA;
    cmd.wrData  = commit & addrValid & latA;
    cmd.wdata   = latD;
  end
endmodule

// File: rtl/idx_reg_port_dp.sv
module idx_reg_port_dp
  import idx_reg_port_pkg::*;
#(
  parameter int         NUM_GP  = 4,
  parameter int         GP_BASE = 16,
  parameter logic [3:0] VERSION = 4'h3
) (
  input  logic                clk,
  input  logic                rst,
  input  wr_cmd_t             cmd,
  input  logic                rdData,
  input  logic [6:0]          baseAddr,
  output logic [7:0]          dout,
  output logic                doe,
  output logic [NUM_GP*8-1:0] gpFlat,
  output logic                globalEn,
  output logic                delayOff,
  output logic [7:0]          curIndex
);
  localparam logic [7:0] CTRL_IDX = 8'hFF;

  logic [7:0] rdVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      curIndex <= '0;
      globalEn <= 1'b0;
      delayOff <= 1'b0;
    end else begin
      if (cmd.wrIndex) curIndex <= cmd.wdata;
      if (cmd.wrData && curIndex == CTRL_IDX) begin
        globalEn <= cmd.wdata[0];
        delayOff <= cmd.wdata[2];
      end
    end
  end

  for (genvar k = 0; k < NUM_GP; k++) begin : g_gp
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (cmd.wrData && globalEn && int'(curIndex) == GP_BASE + k)
        q <= cmd.wdata;
    end
    assign gpFlat[k*8 +: 8] = q;
  end

  always_comb begin
    rdVal = '0;
    if (curIndex == CTRL_IDX) rdVal = {VERSION, 4'h0};
    else if (globalEn) begin
      if (curIndex == 8'h00) rdVal = {baseAddr, 1'b0};
      for (int k = 0; k < NUM_GP; k++)
        if (int'(curIndex) == GP_BASE + k) rdVal = gpFlat[k*8 +: 8];
    end
  end

  assign dout = rdData ? rdVal : 8'h00;
  assign doe  = rdData;
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
  import idx_reg_port_pkg::*;
#(
  parameter logic [7:0] FIXED_BASE = 8'hD6,
  parameter int         NUM_GP     = 4,
  parameter int         GP_BASE    = 16,
  parameter logic [3:0] VERSION    = 4'h3,
  parameter int         DLY_CYC    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csN,
  input  logic                iowrN,
  input  logic                iordN,
  input  logic [7:0]          addr,
  input  logic [7:0]          din,
  output logic [7:0]          dout,
  output logic                doe,
  output logic [NUM_GP*8-1:0] regsOut,
  output logic                globalEn
);
  wr_cmd_t    cmd;
  logic       rdData, addrValid, fixedMode, delayOff;
  logic [6:0] baseAddr;
  logic [7:0] curIndex;

  idx_reg_port_ctrl #(.FIXED_BASE(FIXED_BASE), .DLY_CYC(DLY_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .iowrN(iowrN), .iordN(iordN),
    .addr(addr), .din(din), .delayOff(delayOff), .cmd(cmd),
    .rdData(rdData), .baseAddr(baseAddr), .addrValid(addrValid),
    .fixedMode(fixedMode)
  );

  idx_reg_port_dp #(.NUM_GP(NUM_GP), .GP_BASE(GP_BASE), .VERSION(VERSION)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .rdData(rdData), .baseAddr(baseAddr),
    .dout(dout), .doe(doe), .gpFlat(regsOut), .globalEn(globalEn),
    .delayOff(delayOff), .curIndex(curIndex)
  );
endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk #(
  parameter int         NUM_GP  = 4,
  parameter logic [3:0] VERSION = 4'h3
) (
  input logic                clk,
  input logic                rst,
  input logic                csN,
  input logic                iordN,
  input logic [7:0]          addr,
  input logic [7:0]          dout,
  input logic                doe,
  input logic [NUM_GP*8-1:0] regsOut,
  input logic                globalEn,
  input logic                addrValid,
  input logic                fixedMode,
  input logic [7:0]          curIndex
);
  p_fixed_base_r1: assert property (@(posedge clk) disable iff (rst)
    fixedMode |-> addrValid);
  p_no_read_uncaptured_r3: assert property (@(posedge clk) disable iff (rst)
    !addrValid |-> !doe);
  p_read_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    doe |-> (!csN && !iordN));
  p_index_write_only_r5: assert property (@(posedge clk) disable iff (rst)
    doe |-> addr[0]);
  p_disabled_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (doe && !globalEn && curIndex != 8'hFF) |-> dout == 8'h00);
  p_gp_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !globalEn |=> $stable(regsOut));
  p_version_r8: assert property (@(posedge clk) disable iff (rst)
    (doe && curIndex == 8'hFF) |-> dout == {VERSION, 4'h0});
endmodule

bind idx_reg_port idx_reg_port_chk #(.NUM_GP(NUM_GP), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst(rst), .csN(csN), .iordN(iordN), .addr(addr), .dout(dout),
  .doe(doe), .regsOut(regsOut), .globalEn(globalEn), .addrValid(addrValid),
  .fixedMode(fixedMode), .curIndex(curIndex)
);

// File: tb/idx_reg_port_tb.sv
module idx_reg_port_tb;
  localparam int PERIOD = 10;

  logic        clk = 0, rst = 1, csN = 1, iowrN = 1, iordN = 1;
  logic [7:0]  addr = 0, din = 0;
  logic [7:0]  dout;
  logic        doe, globalEn;
  logic [31:0] regsOut;

  int  nRun = 0, nFail = 0;
  bit  watchOn = 0;

  // behavioural reference state
  logic [6:0] mBase;
  bit         mValid, mEn, mDlyOff;
  logic [7:0] mIdx;
  logic [7:0] mGp [4];

  always #(PERIOD/2) clk = ~clk;

  idx_reg_port u_dut (.clk(clk), .rst(rst), .csN(csN), .iowrN(iowrN), .iordN(iordN),
    .addr(addr), .din(din), .dout(dout), .doe(doe), .regsOut(regsOut), .globalEn(globalEn));

  function automatic logic [31:0] mPacked();
    return {mGp[3], mGp[2], mGp[1], mGp[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // compared on every clock while the bus is quiet
  always @(negedge clk)
    if (watchOn && !rst) begin
      check("R7 regsOut", regsOut, mPacked());
      check("R6 globalEn", {31'd0, globalEn}, {31'd0, mEn});
    end

  task automatic doReset(logic strap);
    watchOn = 0;
    @(negedge clk);
    rst = 1; csN = strap; iowrN = 1; iordN = 1;
    repeat (3) @(negedge clk);
    rst = 0; csN = 1;
    mValid = !strap; mBase = strap ? 7'd0 : 7'h6B;
    mEn = 0; mDlyOff = 0; mIdx = 0;
    for (int k = 0; k < 4; k++) mGp[k] = 0;
    watchOn = 1;
  endtask

  function automatic void modelWrite(logic [7:0] a, logic [7:0] d);
    if (!mValid) begin
      mBase = d[7:1]; mValid = 1;
    end else if (a[7:1] == mBase) begin
      if (!a[0]) mIdx = d;
      else if (mIdx == 8'hFF) begin mEn = d[0]; mDlyOff = d[2]; end
      else if (mEn && mIdx >= 8'h10 && mIdx <= 8'h13) mGp[mIdx - 8'h10] = d;
    end
  endfunction

  // timed: compare regsOut after each edge following release (R10)
  task automatic busWrite(logic [7:0] a, logic [7:0] d, bit timed = 0);
    logic [31:0] oldV, newV;
    int lat;
    watchOn = 0;
    oldV = mPacked();
    lat = mDlyOff ? 2 : 4;
    modelWrite(a, d);
    newV = mPacked();
    addr = a; din = d; csN = 0; iowrN = 0;
    repeat (2) @(negedge clk);
    csN = 1; iowrN = 1;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); @(negedge clk);
      if (timed) check($sformatf("R10 edge %0d", k), regsOut, (k >= lat) ? newV : oldV);
    end
    watchOn = 1;
  endtask

  task automatic busRead(string req, logic [7:0] a);
    bit expOe;
    logic [7:0] expV;
    expOe = mValid && a[7:1] == mBase && a[0];
    expV = 8'h00;
    if (expOe) begin
      if (mIdx == 8'hFF) expV = 8'h30;
      else if (mEn && mIdx == 8'h00) expV = {mBase, 1'b0};
      else if (mEn && mIdx >= 8'h10 && mIdx <= 8'h13) expV = mGp[mIdx - 8'h10];
    end
    @(negedge clk);
    addr = a; csN = 0; iordN = 0;
    #1;
    check({req, " oe"}, {31'd0, doe}, {31'd0, expOe});
    check({req, " data"}, {24'd0, dout}, {24'd0, expV});
    @(negedge clk);
    csN = 1; iordN = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1: fixed base after a reset with chip select low
    doReset(1'b0);
    @(negedge clk);
    check("R1 reset regsOut", regsOut, 32'h0);
    check("R1 reset enable", {31'd0, globalEn}, 32'd0);
    busRead("R1 data port at D7", 8'hD7);
    busWrite(8'hD6, 8'hFF);
    busRead("R8 version", 8'hD7);
    // R6: disabled access
    busWrite(8'hD6, 8'h10);
    busWrite(8'hD7, 8'h5A);
    busRead("R6 gp disabled", 8'hD7);
    busWrite(8'hD6, 8'h00);
    busRead("R6 base disabled", 8'hD7);
    // enable, delay kept on
    busWrite(8'hD6, 8'hFF);
    busWrite(8'hD7, 8'h01);
    busRead("R8 version enabled", 8'hD7);
    busWrite(8'hD6, 8'h00);
    busRead("R11 base readback", 8'hD7);
    busWrite(8'hD6, 8'h10);
    busWrite(8'hD7, 8'hA5, 1);            // R10 delayed
    busRead("R7 gp0", 8'hD7);
    busWrite(8'hD6, 8'hFF);
    busWrite(8'hD7, 8'h05);               // delay off
    busWrite(8'hD6, 8'h11);
    busWrite(8'hD7, 8'h3C, 1);            // R10 undelayed
    busWrite(8'hD6, 8'h12);
    busWrite(8'hD7, 8'hC3, 1);
    busWrite(8'hD6, 8'h13);
    busWrite(8'hD7, 8'h7E, 1);
    for (int k = 0; k < 4; k++) begin
      busWrite(8'hD6, 8'h10 + 8'(k));
      busRead("R7 gp readback", 8'hD7);
    end
    busWrite(8'hD6, 8'h20);
    busRead("R9 unimplemented", 8'hD7);
    // R4: foreign address
    busWrite(8'h40, 8'h13);
    busWrite(8'h41, 8'h99);
    busRead("R4 foreign read", 8'h41);
    busWrite(8'hD6, 8'h10);
    busRead("R4 gp0 untouched", 8'hD7);
    busRead("R5 pointer port read", 8'hD6);
    // disable again: registers keep contents but access closes
    busWrite(8'hD6, 8'hFF);
    busWrite(8'hD7, 8'h04);
    busWrite(8'hD6, 8'h11);
    busWrite(8'hD7, 8'h00);
    busRead("R6 read after disable", 8'hD7);
    // R2/R3: programmable base
    doReset(1'b1);
    busRead("R3 before capture D7", 8'hD7);
    busRead("R3 before capture 51", 8'h51);
    busWrite(8'h00, 8'h50);               // captures base 50h
    busRead("R2 old base ignored", 8'hD7);
    busWrite(8'h50, 8'hFF);
    busRead("R2 version at new base", 8'h51);
    busWrite(8'h50, 8'h01);
    busWrite(8'h51, 8'h01);
    busWrite(8'h50, 8'h00);
    busRead("R2 base readback", 8'h51);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule